// File: doc/BRIEF.md
# Prescaled Millisecond Watchdog Timer

This block is a memory-mapped watchdog for a system-on-chip. An 18-bit prescaler divides the input clock into a tick. Software normally programs the divide value to the clock rate over 1000, which gives one tick per millisecond. An elapsed-tick counter then climbs toward a 16-bit limit. If the limit is reached and reset generation is enabled, the block raises a reset request for a fixed number of clock cycles.

Software keeps the system alive by writing to a restart register at any time before the limit is reached. The data of that write does not matter. The control register holds the prescale value and five single-bit switches:

- clock gate
- prescaler enable
- count enable
- reset enable
- forced reset

The control register reads back exactly as written, so software can change one bit with a read-modify-write.

The bus is a plain single-cycle register port. A write takes effect at the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`. The reset request is a level output for the system reset controller.

Top module: `wdg_timer`

## Requirements
- R1: After reset, every register reads zero and `rst_req` is low.
- R2: Offsets 0x0 (control), 0x8 (timeout) and 0xC (restart) are decoded. The control register stores and reads back all 32 written bits. Any other offset reads zero.
- R3: The prescaler produces one tick every D clock edges, where D is control bits 17:0 and D=0 acts as 1. It ticks only while control bit 24 (clock gate) and bit 25 (prescaler enable) are both set.
- R4: Clearing control bit 25 returns the prescaler phase to zero, so the first tick after re-enabling comes D edges after the enable takes effect.
- R5: While control bit 18 is set, the elapsed count rises by one on each tick. While it is clear, the elapsed count holds its value.
- R6: Timeout register bits 15:0 hold the limit (read-write, maximum 65535). Bits 31:16 read the elapsed count, and writes to them are ignored.
- R7: Any write to the restart offset sets the elapsed count to zero at that edge. The written data is ignored, and the control and limit registers are not changed.
- R8: When a counted tick brings the elapsed count to the limit, the count returns to zero at that edge (expiry). A limit of zero freezes counting.
- R9: On expiry with control bit 21 set, `rst_req` goes high from the following cycle for PULSE_CYCLES cycles. With bit 21 clear, expiry produces no request.
- R10: While control bit 26 is set, `rst_req` is high from the cycle after the write, whatever the count or the other enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| rst_req | output | 1 | Reset request to the system reset controller |

## Verification
The bench keeps the default 18-bit prescale field and 16-bit limit, and overrides PULSE_CYCLES to 3 so that the pulse edges are easy to count. At run time it programs divide values of 2, 4 and 10 with limits of 5 and 100. This puts expiry, pulse timing, the prescaler phase restart and keep-alive kicking within a few dozen cycles. The 65535 limit ceiling and the read-only upper half are covered by register readback, not by counting that far.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_LIMIT = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_KICK  = 4'hC;

  localparam int BIT_CNT_EN = 18;
  localparam int BIT_RST_EN = 21;
  localparam int BIT_CLK_EN = 24;
  localparam int BIT_DIV_EN = 25;
  localparam int BIT_FORCE  = 26;

  localparam int CNT_LSB = 16;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int DIV_W = 18,
  parameter int LIM_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LIM_W-1:0]  elapsed,
  output logic [DATA_W-1:0] rdata,
  output logic [DIV_W-1:0]  div,
  output logic              clk_en,
  output logic              div_en,
  output logic              cnt_en,
  output logic              rst_en,
  output logic              force_rst,
  output logic [LIM_W-1:0]  limit,
  output logic              kick
);
  logic [DATA_W-1:0] ctrl_q;
  logic [LIM_W-1:0]  limit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      limit_q <= '0;
    end else if (wr) begin
      if (addr == OFS_CTRL)  ctrl_q  <= wdata;
      if (addr == OFS_LIMIT) limit_q <= wdata[LIM_W-1:0];
    end
  end

  assign kick = wr && (addr == OFS_KICK);

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CTRL: rdata = ctrl_q;
      OFS_LIMIT: begin
        rdata[LIM_W-1:0]         = limit_q;
        rdata[CNT_LSB +: LIM_W]  = elapsed;
      end
      default: rdata = '0;
    endcase
  end

  assign div       = ctrl_q[DIV_W-1:0];
  assign clk_en    = ctrl_q[BIT_CLK_EN];
  assign div_en    = ctrl_q[BIT_DIV_EN];
  assign cnt_en    = ctrl_q[BIT_CNT_EN];
  assign rst_en    = ctrl_q[BIT_RST_EN];
  assign force_rst = ctrl_q[BIT_FORCE];
  assign limit     = limit_q;
endmodule

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
  parameter int DIV_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             div_en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] phase_q;
  logic             last;

  assign last = (div == '0) || (phase_q >= div - DIV_W'(1));
  assign tick = clk_en && div_en && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (!div_en) phase_q <= '0;
    else if (clk_en)  phase_q <= last ? '0 : phase_q + DIV_W'(1);
  end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int LIM_W        = 16,
  parameter int PULSE_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_en,
  input  logic             rst_en,
  input  logic             kick,
  input  logic [LIM_W-1:0] limit,
  output logic [LIM_W-1:0] elapsed,
  output logic             pulse
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);

  logic [LIM_W-1:0] elapsed_q;
  logic [PW-1:0]    pulse_q;
  logic             step;
  logic             hit;
  logic [LIM_W:0]   next_cnt;

  assign next_cnt = {1'b0, elapsed_q} + (LIM_W+1)'(1);
  assign step     = tick && cnt_en && (limit != '0) && !kick;
  assign hit      = step && (next_cnt >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    elapsed_q <= '0;
    else if (kick) elapsed_q <= '0;
    else if (hit)  elapsed_q <= '0;
    else if (step) elapsed_q <= next_cnt[LIM_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pulse_q <= '0;
    else if (hit && rst_en)   pulse_q <= PW'(PULSE_CYCLES);
    else if (pulse_q != '0)   pulse_q <= pulse_q - PW'(1);
  end

  assign elapsed = elapsed_q;
  assign pulse   = (pulse_q != '0);
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int DIV_W        = 18,
  parameter int LIM_W        = 16,
  parameter int PULSE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  logic [DIV_W-1:0] div;
  logic             clk_en, div_en, cnt_en, rst_en, force_rst;
  logic [LIM_W-1:0] limit;
  logic [LIM_W-1:0] elapsed;
  logic             kick, tick, pulse;

  wdg_regs #(.DIV_W(DIV_W), .LIM_W(LIM_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .elapsed(elapsed), .rdata(bus_rdata), .div(div), .clk_en(clk_en),
    .div_en(div_en), .cnt_en(cnt_en), .rst_en(rst_en), .force_rst(force_rst),
    .limit(limit), .kick(kick)
  );

  wdg_prescale #(.DIV_W(DIV_W)) u_prescale (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .div_en(div_en), .div(div),
    .tick(tick)
  );

  wdg_counter #(.LIM_W(LIM_W), .PULSE_CYCLES(PULSE_CYCLES)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_en(cnt_en), .rst_en(rst_en),
    .kick(kick), .limit(limit), .elapsed(elapsed), .pulse(pulse)
  );

  assign rst_req = pulse || force_rst;
endmodule

// File: rtl/wdg_timer_chk.sv
module wdg_timer_chk
  import wdg_pkg::*;
#(
  parameter int LIM_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rst_req,
  input logic              cnt_en,
  input logic              rst_en,
  input logic              force_rst,
  input logic [LIM_W-1:0]  elapsed
);
  logic kick_seen;
  logic force_wr;
  assign kick_seen = bus_wr && (bus_addr == OFS_KICK);
  assign force_wr  = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[BIT_FORCE];

  AST_FORCE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(force_wr) |-> rst_req); // R10

  AST_KICK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(kick_seen) |-> (elapsed == '0)); // R7

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cnt_en) && !$past(kick_seen)) |-> (elapsed == $past(elapsed))); // R5

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (elapsed != $past(elapsed)) |->
      ((elapsed == '0) || (elapsed == $past(elapsed) + LIM_W'(1)))); // R8

  AST_PULSE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_req) && !force_rst) |-> $past(rst_en)); // R9
endmodule

bind wdg_timer wdg_timer_chk #(.LIM_W(LIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rst_req(rst_req), .cnt_en(cnt_en), .rst_en(rst_en),
  .force_rst(force_rst), .elapsed(elapsed)
);

// File: tb/test_wdg_timer.sv
`timescale 1ns/1ps
module test_wdg_timer;
  localparam int PULSE = 3;
  localparam logic [31:0] B_CNT = 32'h1 << 18;
  localparam logic [31:0] B_RST = 32'h1 << 21;
  localparam logic [31:0] B_CLK = 32'h1 << 24;
  localparam logic [31:0] B_DIV = 32'h1 << 25;
  localparam logic [31:0] B_FRC = 32'h1 << 26;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int n_tests = 0;
  int n_fail  = 0;
  logic mon_en = 1'b0;
  int   mon_hits = 0;

  always #10 clk = ~clk;

  wdg_timer #(.PULSE_CYCLES(PULSE)) i_wdg_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  always @(negedge clk) if (mon_en && rst_req) mon_hits++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd_reg(4'h0, v); check("R1 ctrl", v, 32'h0);
    rd_reg(4'h8, v); check("R1 timeout", v, 32'h0);
    check("R1 rst_req", {31'h0, rst_req}, 32'h0);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr_reg(4'h0, 32'h5A3C_1234);
    rd_reg(4'h0, v); check("R2 ctrl readback", v, 32'h5A3C_1234);
    rd_reg(4'h4, v); check("R2 unmapped", v, 32'h0);
    wr_reg(4'h8, 32'd100);
    repeat (30) @(negedge clk);
    rd_reg(4'h8, v); check("R3 clock gate off no count", v, 32'd100);
    check("R10 no force", {31'h0, rst_req}, 32'h0);
    wr_reg(4'h0, 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    logic [31:0] run;
    run = 32'd4 | B_CLK | B_DIV | B_CNT;
    wr_reg(4'hC, 32'h0);
    wr_reg(4'h0, run);
    repeat (40) @(negedge clk);
    rd_reg(4'h8, v); check("R3 R5 ten ticks", v[31:16], 32'd10);
    wr_reg(4'h0, run & ~B_CNT);
    rd_reg(4'h0, v); check("R5 fields kept", v, run & ~B_CNT);
    repeat (20) @(negedge clk);
    rd_reg(4'h8, v); check("R5 hold when disabled", v[31:16], 32'd10);
    wr_reg(4'hC, 32'hFFFF_FFFF);
    rd_reg(4'h8, v); check("R7 kick zero, limit kept", v, 32'd100);
    rd_reg(4'h0, v); check("R7 ctrl untouched", v, run & ~B_CNT);
    wr_reg(4'h0, 32'h0);
  endtask

  task automatic t_expire(input logic with_rst);
    logic [31:0] v;
    int first = -1;
    int hits = 0;
    logic [31:0] c9 = '0, c10 = '1;
    wr_reg(4'h0, 32'h0);
    wr_reg(4'h8, 32'd5);
    wr_reg(4'hC, 32'h0);
    wr_reg(4'h0, 32'd2 | B_CLK | B_DIV | B_CNT | (with_rst ? B_RST : 32'h0));
    bus_addr = 4'h8;
    for (int i = 1; i <= 14; i++) begin
      @(negedge clk);
      #1;
      if (rst_req) begin
        hits++;
        if (first < 0) first = i;
      end
      if (i == 9)  c9  = {16'h0, bus_rdata[31:16]};
      if (i == 10) c10 = {16'h0, bus_rdata[31:16]};
    end
    check("R8 count before expiry", c9, 32'd4);
    check("R8 count wraps at expiry", c10, 32'd0);
    if (with_rst) begin
      check("R9 pulse start", first, 32'd10);
      check("R9 pulse width", hits, PULSE);
    end else begin
      check("R9 no pulse when disabled", hits, 32'd0);
    end
    wr_reg(4'h0, 32'h0);
    repeat (5) @(negedge clk);
    rd_reg(4'h0, v);
  endtask

  task automatic t_keepalive();
    wr_reg(4'h0, 32'h0);
    wr_reg(4'h8, 32'd5);
    wr_reg(4'hC, 32'h0);
    wr_reg(4'h0, 32'd2 | B_CLK | B_DIV | B_CNT | B_RST);
    mon_hits = 0; mon_en = 1'b1;
    for (int k = 0; k < 10; k++) begin
      repeat (4) @(negedge clk);
      wr_reg(4'hC, 32'h1234_5678);
    end
    mon_en = 1'b0;
    check("R7 kicks keep request low", mon_hits, 32'd0);
    mon_hits = 0; mon_en = 1'b1;
    repeat (14) @(negedge clk);
    mon_en = 1'b0;
    check("R9 request once kicks stop", mon_hits, PULSE);
    wr_reg(4'h0, 32'h0);
  endtask

  task automatic t_force();
    logic [31:0] v;
    wr_reg(4'h0, B_FRC);
    check("R10 force immediate", {31'h0, rst_req}, 32'h1);
    repeat (5) @(negedge clk);
    check("R10 force held", {31'h0, rst_req}, 32'h1);
    wr_reg(4'h0, 32'h0);
    check("R10 force released", {31'h0, rst_req}, 32'h0);
    wr_reg(4'hC, 32'h0);
    wr_reg(4'h8, 32'hFFFF_FFFF);
    rd_reg(4'h8, v); check("R6 limit max, upper read-only", v, 32'h0000_FFFF);
  endtask

  task automatic t_phase();
    logic [31:0] v;
    logic [31:0] run;
    run = 32'd10 | B_CLK | B_DIV | B_CNT;
    wr_reg(4'h0, 32'h0);
    wr_reg(4'h8, 32'd100);
    wr_reg(4'hC, 32'h0);
    wr_reg(4'h0, run);
    repeat (2) @(negedge clk);
    wr_reg(4'h0, run & ~B_DIV);
    wr_reg(4'h0, run);
    repeat (9) @(negedge clk);
    rd_reg(4'h8, v); check("R4 no tick before full period", v[31:16], 32'd0);
    @(negedge clk);
    rd_reg(4'h8, v); check("R4 first tick after restart", v[31:16], 32'd1);
    wr_reg(4'h0, 32'h0);
  endtask

  initial begin
    #(20.0 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_count();
    t_expire(1'b1);
    t_expire(1'b0);
    t_keepalive();
    t_force();
    t_phase();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule